// File: doc/BRIEF.md
# Serial EEPROM Station Address Loader

This block pulls a 32-byte configuration image out of a serial EEPROM that is organised as sixteen 16-bit words and reached over the four-wire Microwire pins (chip select, serial clock, data in, data out). After a start pulse it walks the word addresses upward from zero. For each word it bit-bangs a full read command and shifts in sixteen data bits. It splits each word into two bytes.

The bytes are not kept as an image. A running XOR covers the key field, and the stored checksum byte is held aside. The six station-address bytes are caught as they stream past. When the last word is in, the block compares the XOR with the stored checksum. On a match it presents the station address with a valid flag. On a mismatch it raises an error flag and reports the address as zero. Pin timing is set by the `half_period` input. Every pin state is held for `half_period + 1` clock cycles, so a slow EEPROM can be served from a fast system clock.

Top module: `uwire_eeprom_loader`

## Requirements
- R1: In reset, and while idle after reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done`, `addr_valid`, `cksum_err` and `station_addr` are all 0.
- R2: A `start` pulse while idle begins a read of word addresses 0 to N_WORDS-1 in increasing order. A `start` while `busy` is ignored: the running read neither restarts nor lengthens.
- R3: Each word is framed as follows, with DI changing only while SK is low:
  - `ee_cs` low, then `ee_cs` high.
  - One SK rising edge with DI = 0.
  - Three rising edges with DI = 1, 1, 0 (start bit and read opcode).
  - Six rising edges carrying the word address, most significant bit first.
- R4: After the address, SK falls and one dummy sample step passes. Then come sixteen data bits, most significant first. Each bit is sampled after SK has fallen. The first 8 bits form byte 2w and the last 8 bits form byte 2w+1.
- R5: Each pin state lasts `half_period + 1` cycles. A word takes 55 states, 53 of them with `ee_cs` high. A whole read spans 880 × (`half_period` + 1) cycles from the start edge to the `done` edge.
- R6: After the sixteenth data bit, `ee_cs`, `ee_sk` and `ee_di` are all low for two states before the next word's chip select.
- R7: The checksum is the XOR of bytes KEY_OFS (0) through CKSUM_OFS-1 (30). It is compared with byte CKSUM_OFS (31). On a match `addr_valid` = 1 and `cksum_err` = 0. Otherwise `addr_valid` = 0 and `cksum_err` = 1. The two flags are never both 1.
- R8: `station_addr` holds bytes ADDR_OFS (16) through ADDR_OFS+5, with byte ADDR_OFS in bits [47:40] and byte ADDR_OFS+5 in bits [7:0]. It reads as zero unless `addr_valid` = 1.
- R9: `done` is a one-cycle pulse in the cycle `busy` falls. `addr_valid` and `cksum_err` are cleared when a read starts and keep their result after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a read when idle |
| half_period | input | HOLD_W | Pin state hold length minus one, in clock cycles |
| ee_do | input | 1 | EEPROM serial data out |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM serial data in |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle end-of-read pulse |
| addr_valid | output | 1 | Checksum matched; address valid |
| cksum_err | output | 1 | Checksum mismatch |
| station_addr | output | 48 | Six-byte station address, first byte in the top bits |

## Verification
The main read is tried with five images, and each one tells apart a different class of fault:
- All zeros: checks framing alone.
- All ones: exposes a missing dummy step or a bit-slip into the idle level.
- An address ramp: shows whether bytes are swapped or reversed inside a word.
- A mixed pattern: checks the XOR over many varied bits.
- A deliberately corrupted checksum: must raise the error flag and blank the address.

An EEPROM model in the bench serves data only when the command bits and word address arrive in the required order. A framing slip therefore shows up as wrong data or a framing error, not as silence. Hold lengths of 0 to 3 are used to separate the per-state timing from the sequence itself.

// File: rtl/uwire_eeprom_loader.sv
module uwire_eeprom_loader #(
  parameter int HOLD_W    = 8,
  parameter int N_WORDS   = 16,
  parameter int WADDR_W   = 6,
  parameter int KEY_OFS   = 0,
  parameter int ADDR_OFS  = 16,
  parameter int CKSUM_OFS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HOLD_W-1:0] half_period,
  input  logic              ee_do,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  output logic              busy,
  output logic              done,
  output logic              addr_valid,
  output logic              cksum_err,
  output logic [47:0]       station_addr
);
  localparam int DW          = 16;
  localparam int ADDR_LAST   = 8 + 2 * WADDR_W;
  localparam int DUMMY       = ADDR_LAST + 1;
  localparam int DATA_FIRST  = DUMMY + 1;
  localparam int LAST_SAMPLE = DUMMY + 2 * DW;
  localparam int LAST_STEP   = LAST_SAMPLE + 1;
  localparam int STEP_W      = $clog2(LAST_STEP + 1);
  localparam int BIDX_W      = WADDR_W + 1;

  localparam logic [STEP_W-1:0] S_CLK0        = STEP_W'(2);
  localparam logic [STEP_W-1:0] S_OP_FIRST    = STEP_W'(3);
  localparam logic [STEP_W-1:0] S_OP_LAST     = STEP_W'(6);
  localparam logic [STEP_W-1:0] S_ADDR_FIRST  = STEP_W'(9);
  localparam logic [STEP_W-1:0] S_ADDR_LAST   = STEP_W'(ADDR_LAST);
  localparam logic [STEP_W-1:0] S_DATA_FIRST  = STEP_W'(DATA_FIRST);
  localparam logic [STEP_W-1:0] S_LAST_SAMPLE = STEP_W'(LAST_SAMPLE);
  localparam logic [STEP_W-1:0] S_LAST_STEP   = STEP_W'(LAST_STEP);
  localparam logic [WADDR_W-1:0] W_LAST       = WADDR_W'(N_WORDS - 1);

  logic [STEP_W-1:0]  step;
  logic [HOLD_W-1:0]  hold;
  logic [WADDR_W-1:0] word;
  logic [DW-2:0]      shreg;
  logic [7:0]         xacc, ckbyte;
  logic [47:0]        addr_q;
  logic               busy_q, done_q, valid_q, err_q;
  logic               di_r;
  logic [WADDR_W-1:0] ws;

  wire              step_end  = busy_q && (hold == half_period);
  wire              is_sample = step[0] && (step > S_DATA_FIRST) && (step <= S_LAST_SAMPLE);
  wire [DW-1:0]     word_in   = {shreg, ee_do};
  wire [BIDX_W-1:0] bi_hi     = {word, 1'b0};
  wire [BIDX_W-1:0] bi_lo     = {word, 1'b1};
  wire              key_hi    = (int'(bi_hi) >= KEY_OFS) && (int'(bi_hi) < CKSUM_OFS);
  wire              key_lo    = (int'(bi_lo) >= KEY_OFS) && (int'(bi_lo) < CKSUM_OFS);

  always_comb begin
    di_r = 1'b0;
    ws   = word;
    if (step >= S_OP_FIRST && step <= S_OP_LAST) begin
      di_r = 1'b1;
    end else if (step >= S_ADDR_FIRST && step <= S_ADDR_LAST) begin
      ws   = word << ((step - S_ADDR_FIRST) >> 1);
      di_r = ws[WADDR_W-1];
    end
  end

  assign ee_cs = busy_q && (step != '0) && (step != S_LAST_STEP);
  assign ee_sk = busy_q && !step[0] &&
                 ((step >= S_CLK0 && step <= S_ADDR_LAST) ||
                  (step >= S_DATA_FIRST && step < S_LAST_SAMPLE));
  assign ee_di = busy_q && di_r;

  assign busy         = busy_q;
  assign done         = done_q;
  assign addr_valid   = valid_q;
  assign cksum_err    = err_q;
  assign station_addr = valid_q ? addr_q : 48'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step    <= '0;
      hold    <= '0;
      word    <= '0;
      shreg   <= '0;
      xacc    <= '0;
      ckbyte  <= '0;
      addr_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          step    <= '0;
          hold    <= '0;
          word    <= '0;
          xacc    <= '0;
          ckbyte  <= '0;
          addr_q  <= '0;
          valid_q <= 1'b0;
          err_q   <= 1'b0;
        end
      end else begin
        hold <= step_end ? '0 : hold + 1'b1;
        if (step_end) begin
          if (is_sample) shreg <= word_in[DW-2:0];
          if (step == S_LAST_SAMPLE) begin
            xacc <= xacc ^ (key_hi ? word_in[15:8] : 8'h00) ^ (key_lo ? word_in[7:0] : 8'h00);
            if (int'(bi_hi) == CKSUM_OFS) ckbyte <= word_in[15:8];
            if (int'(bi_lo) == CKSUM_OFS) ckbyte <= word_in[7:0];
            for (int k = 0; k < 6; k++) begin
              if (int'(bi_hi) == ADDR_OFS + k) addr_q[47-8*k -: 8] <= word_in[15:8];
              if (int'(bi_lo) == ADDR_OFS + k) addr_q[47-8*k -: 8] <= word_in[7:0];
            end
          end
          if (step == S_LAST_STEP) begin
            step <= '0;
            if (word == W_LAST) begin
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              valid_q <= (xacc == ckbyte);
              err_q   <= (xacc != ckbyte);
            end else begin
              word <= word + 1'b1;
            end
          end else begin
            step <= step + 1'b1;
          end
        end
      end
    end
  end
endmodule

module uwire_eeprom_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di,
  input logic addr_valid,
  input logic cksum_err
);
  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs); // R3
  AST_DI_STABLE_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di)); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R2
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_valid && cksum_err)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $fell(busy))); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!addr_valid && !cksum_err)); // R9
endmodule

bind uwire_eeprom_loader uwire_eeprom_loader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
  .addr_valid(addr_valid), .cksum_err(cksum_err)
);

// File: tb/uwire_eeprom_loader_tb_top.sv
module uwire_eeprom_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  half_period = 8'd0;
  logic        ee_do;
  logic        ee_cs, ee_sk, ee_di, busy, done, addr_valid, cksum_err;
  logic [47:0] station_addr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  uwire_eeprom_loader dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .half_period(half_period),
    .ee_do(ee_do), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .busy(busy), .done(done), .addr_valid(addr_valid), .cksum_err(cksum_err),
    .station_addr(station_addr)
  );

  // EEPROM model: answers only a correctly framed read command
  logic [7:0] img [32];
  int         edge_n = 0;
  int         frame_err = 0;
  int         next_exp = 0;
  logic [5:0] a_cap = '0;
  logic [15:0] cur = '0;
  logic       m_do = 1'b0;
  assign ee_do = m_do;

  always @(negedge ee_cs) edge_n = 0;

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      edge_n = edge_n + 1;
      if (edge_n == 1 && ee_di !== 1'b0) frame_err++;
      if ((edge_n == 2 || edge_n == 3) && ee_di !== 1'b1) frame_err++;
      if (edge_n == 4 && ee_di !== 1'b0) frame_err++;
      if (edge_n >= 5 && edge_n <= 10) a_cap = {a_cap[4:0], ee_di};
      if (edge_n == 10) begin
        if (int'(a_cap) != next_exp || a_cap >= 6'd16) frame_err++;
        next_exp++;
        cur = {img[2*a_cap[3:0]], img[2*a_cap[3:0]+1]};
        m_do <= 1'b0;
      end
      if (edge_n >= 11 && edge_n <= 26) m_do <= cur[26-edge_n];
      if (edge_n > 26) frame_err++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [7:0] exp_ck;
  logic [47:0] exp_addr;

  task automatic load(input logic [7:0] mul, input logic [7:0] add, input bit bad);
    logic [7:0] x;
    x = 8'h00;
    for (int i = 0; i < 31; i++) begin
      img[i] = 8'(i * mul + add);
      x = x ^ img[i];
    end
    img[31] = bad ? (x ^ 8'h01) : x;
    exp_addr = {img[16], img[17], img[18], img[19], img[20], img[21]};
  endtask

  task automatic run_read(input logic [7:0] h, input bit inject, output int cnt);
    half_period = h;
    frame_err = 0;
    next_exp = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 50000) begin
      if (busy) cnt++;
      if (inject && cnt == 300) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  // vector: {mul, add, bad, hold}
  localparam logic [24:0] VEC [5] = '{
    {8'h00, 8'h00, 1'b0, 8'd0},
    {8'h00, 8'hFF, 1'b0, 8'd1},
    {8'h01, 8'h30, 1'b0, 8'd3},
    {8'h3B, 8'h5A, 1'b1, 8'd0},
    {8'hA5, 8'hC3, 1'b0, 8'd2}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cnt;
    int hi_n;
    int lo_n;
    repeat (3) @(negedge clk);
    chk({ee_cs, ee_sk, ee_di, busy, done, addr_valid, cksum_err} == 7'b0 && station_addr == 48'h0,
        "R1 in reset", {ee_cs, ee_sk, ee_di, busy, done, addr_valid, cksum_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({ee_cs, ee_sk, ee_di, busy, addr_valid, cksum_err} == 6'b0,
        "R1 idle", {ee_cs, ee_sk, ee_di, busy, addr_valid, cksum_err}, 0);

    foreach (VEC[v]) begin
      load(VEC[v][24:17], VEC[v][16:9], VEC[v][8]);
      run_read(VEC[v][7:0], 1'b0, cnt);
      chk(done == 1'b1, "R9 done pulse", done, 1);
      chk(cnt == 880 * (int'(VEC[v][7:0]) + 1), "R5 read length", cnt, 880 * (int'(VEC[v][7:0]) + 1));
      chk(frame_err == 0 && next_exp == 16, "R3 R2 framing and word order", frame_err * 256 + next_exp, 16);
      chk(addr_valid == !VEC[v][8], "R7 valid flag", addr_valid, !VEC[v][8]);
      chk(cksum_err == VEC[v][8], "R7 error flag", cksum_err, VEC[v][8]);
      chk(station_addr == (VEC[v][8] ? 48'h0 : exp_addr), "R4 R8 station address",
          station_addr, VEC[v][8] ? 48'h0 : exp_addr);
      @(negedge clk);
      chk(done == 1'b0 && addr_valid == !VEC[v][8], "R9 pulse ends, flags held", {done, addr_valid}, {1'b0, !VEC[v][8]});
    end

    // start while busy is ignored
    load(8'h07, 8'h11, 1'b0);
    run_read(8'd0, 1'b1, cnt);
    chk(cnt == 880, "R2 start ignored while busy", cnt, 880);
    chk(next_exp == 16 && frame_err == 0, "R2 single pass", next_exp, 16);
    chk(station_addr == exp_addr && addr_valid, "R8 address after ignored start", station_addr, exp_addr);

    // chip-select timing and inter-word gap
    half_period = 8'd2;
    frame_err = 0;
    next_exp = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!ee_cs) @(negedge clk);
    hi_n = 0;
    while (ee_cs) begin
      hi_n++;
      @(negedge clk);
    end
    lo_n = 0;
    while (!ee_cs) begin
      if (ee_sk || ee_di) lo_n = lo_n + 1000;
      lo_n++;
      @(negedge clk);
    end
    chk(hi_n == 53 * 3, "R5 cs high length", hi_n, 159);
    chk(lo_n == 2 * 3, "R6 pins low between words", lo_n, 6);
    while (!done) @(negedge clk);
    chk(addr_valid && station_addr == exp_addr, "R8 address after timing run", station_addr, exp_addr);

    // reset in the middle of a read
    load(8'h13, 8'h02, 1'b0);
    half_period = 8'd1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (300) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({ee_cs, ee_sk, ee_di, busy, addr_valid, cksum_err} == 6'b0,
        "R1 reset mid-read", {ee_cs, ee_sk, ee_di, busy, addr_valid, cksum_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_read(8'd1, 1'b0, cnt);
    chk(cnt == 1760 && frame_err == 0, "R5 read after reset", cnt, 1760);
    chk(addr_valid && station_addr == exp_addr, "R8 address after reset", station_addr, exp_addr);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule